// File: doc/BRIEF.md
# Two-Source Interrupt Combiner

This block merges two event sources into a small status register and a single active-low interrupt pin. Source 0 is a pulse that marks the end of a copy from the user-side buffer into the transmit-side buffer. Source 1 comes from one of two conditions, a data-slip condition or a block-start condition. A select bit in the mask register chooses which one.

Each source has its own enable bit and its own 2-bit trigger mode: rising edge, falling edge, level, or off. In the edge modes a status bit stays set until software reads the status register. In level mode the bit follows the enabled input, one clock late. The interrupt pin is low whenever any status bit is set.

Software reaches three registers through a single-cycle read/write port. Reads are combinational on the address. A read of the status register clears the edge-captured bits at the next clock edge.

Top module: `irq_combiner`

## Requirements
- R1: After reset, the status register (address 0), the mask register (address 1) and the mode register (address 2) all read 0x00, and `irq_n_o` is 1.
- R2: The mask register keeps only bits [2:0]. Bit 0 enables source 0, bit 1 enables source 1, and bit 2 is the source-1 select. The mode register keeps only bits [3:0]: bits [1:0] are the source-0 mode and bits [3:2] are the source-1 mode. All other bits read 0.
- R3: With mode 00 (rising edge) and the source enabled, a 0-to-1 change on its input sets its status bit (bit 0 for source 0, bit 1 for source 1) at the first clock edge that sees the new value. The bit stays set after the input falls.
- R4: With mode 01 (falling edge) and the source enabled, a 1-to-0 change on the input sets its status bit at the first clock edge that sees the new value. A rising change does not set it.
- R5: With mode 10 (level), the status bit equals (enable AND input) as sampled at the previous clock edge. It clears by itself when the input drops.
- R6: With mode 11, the source never sets its status bit.
- R7: While a source's enable bit is 0, no activity on its input sets its status bit.
- R8: A read of address 0 clears the edge-captured status bits at that clock edge. If a new qualifying edge arrives in the same cycle as the read, the bit stays set.
- R9: When select is 0, source 1 follows `slip_i` and ignores `blk_start_i`. When select is 1, source 1 follows `blk_start_i` and ignores `slip_i`.
- R10: Changing the select bit while the newly chosen input is already steady high creates no edge event.
- R11: `irq_n_o` is 0 exactly when at least one status bit is set.
- R12: Writes to address 0 have no effect. Status bits [7:2] always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| xfer_done_i | input | 1 | Buffer-copy-complete event (source 0) |
| slip_i | input | 1 | Data-slip condition (source 1, select = 0) |
| blk_start_i | input | 1 | Block-start condition (source 1, select = 1) |
| reg_we_i | input | 1 | Register write strobe |
| reg_re_i | input | 1 | Register read strobe (a read of address 0 clears edge flags) |
| reg_addr_i | input | ADDR_W | Register address: 0 status, 1 mask, 2 mode |
| reg_wdata_i | input | DATA_W | Write data |
| reg_rdata_o | output | DATA_W | Read data for `reg_addr_i` |
| irq_n_o | output | 1 | Active-low interrupt, low while any status bit is set |

## Verification
On every cycle, the checker confirms four things: a disabled source never raises its flag, mode 11 never raises a flag, a rising edge on source 0 in rising mode sets its flag, and level mode tracks the enabled input one clock late. It also confirms that the unused status bits read 0.

Some behaviour only shows up in the bench's scenarios, because it depends on ordered stimulus across many cycles:
- read-to-clear, including a read that lands in the same cycle as a new edge;
- the select bit routing source 1 and ignoring the other input;
- the absence of a false edge when select changes;
- the full sweep of mode against enable for both sources.

// File: rtl/irq_pkg.sv
package irq_pkg;

  typedef enum logic [1:0] {
    TRIG_RISE  = 2'b00,
    TRIG_FALL  = 2'b01,
    TRIG_LEVEL = 2'b10,
    TRIG_OFF   = 2'b11
  } trig_mode_e;

  localparam int NSRC        = 2;
  localparam int MODE_W      = 2;
  localparam int ADDR_STATUS = 0;
  localparam int ADDR_MASK   = 1;
  localparam int ADDR_MODE   = 2;

endpackage

// File: rtl/irq_trig_cell.sv
module irq_trig_cell
  import irq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       lvl_i,
  input  logic       lvl_q_i,
  input  trig_mode_e mode_i,
  input  logic       en_i,
  input  logic       clr_i,
  output logic       flag_o
);

  logic flag_q;
  logic flag_d;
  logic rise;
  logic fall;

  always_comb begin
    rise = lvl_i & ~lvl_q_i;
    fall = ~lvl_i & lvl_q_i;
    unique case (mode_i)
      TRIG_RISE:  flag_d = (flag_q & ~clr_i) | (en_i & rise);
      TRIG_FALL:  flag_d = (flag_q & ~clr_i) | (en_i & fall);
      TRIG_LEVEL: flag_d = en_i & lvl_i;
      default:    flag_d = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= flag_d;
  end

  assign flag_o = flag_q;

endmodule

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs
  import irq_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   we_i,
  input  logic                   re_i,
  input  logic [ADDR_W-1:0]      addr_i,
  input  logic [DATA_W-1:0]      wdata_i,
  input  logic [NSRC-1:0]        status_i,
  output logic [NSRC-1:0]        mask_o,
  output logic                   sel_o,
  output logic [NSRC*MODE_W-1:0] mode_o,
  output logic                   stat_clr_o,
  output logic [DATA_W-1:0]      rdata_o
);

  localparam int MODE_BITS = NSRC * MODE_W;

  logic [NSRC-1:0]      mask_q, mask_d;
  logic                 sel_q, sel_d;
  logic [MODE_BITS-1:0] mode_q, mode_d;
  logic                 hit_stat, hit_mask, hit_mode;
  logic                 unused_wbits;

  assign hit_stat = (addr_i == ADDR_W'(ADDR_STATUS));
  assign hit_mask = (addr_i == ADDR_W'(ADDR_MASK));
  assign hit_mode = (addr_i == ADDR_W'(ADDR_MODE));
  assign unused_wbits = ^wdata_i[DATA_W-1:MODE_BITS];

  always_comb begin
    mask_d = mask_q;
    sel_d  = sel_q;
    mode_d = mode_q;
    if (we_i && hit_mask) begin
      mask_d = wdata_i[NSRC-1:0];
      sel_d  = wdata_i[NSRC];
    end
    if (we_i && hit_mode) begin
      mode_d = wdata_i[MODE_BITS-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      sel_q  <= 1'b0;
      mode_q <= '0;
    end else begin
      mask_q <= mask_d;
      sel_q  <= sel_d;
      mode_q <= mode_d;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (hit_stat)      rdata_o = DATA_W'(status_i);
    else if (hit_mask) rdata_o = DATA_W'({sel_q, mask_q});
    else if (hit_mode) rdata_o = DATA_W'(mode_q);
  end

  assign stat_clr_o = re_i & hit_stat;
  assign mask_o     = mask_q;
  assign sel_o      = sel_q;
  assign mode_o     = mode_q;

endmodule

// File: rtl/irq_combiner.sv
module irq_combiner
  import irq_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              xfer_done_i,
  input  logic              slip_i,
  input  logic              blk_start_i,
  input  logic              reg_we_i,
  input  logic              reg_re_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              irq_n_o
);

  localparam int MODE_BITS = NSRC * MODE_W;

  logic                 xfer_q, slip_q, blk_q;
  logic [NSRC-1:0]      src_now, src_prev;
  logic [NSRC-1:0]      status_q;
  logic [NSRC-1:0]      mask_q;
  logic                 sel_q;
  logic [MODE_BITS-1:0] mode_q;
  logic                 stat_clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      xfer_q <= 1'b0;
      slip_q <= 1'b0;
      blk_q  <= 1'b0;
    end else begin
      xfer_q <= xfer_done_i;
      slip_q <= slip_i;
      blk_q  <= blk_start_i;
    end
  end

  always_comb begin
    src_now[0]  = xfer_done_i;
    src_prev[0] = xfer_q;
    src_now[1]  = sel_q ? blk_start_i : slip_i;
    src_prev[1] = sel_q ? blk_q : slip_q;
  end

  irq_cfg_regs #(
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W)
  ) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .we_i       (reg_we_i),
    .re_i       (reg_re_i),
    .addr_i     (reg_addr_i),
    .wdata_i    (reg_wdata_i),
    .status_i   (status_q),
    .mask_o     (mask_q),
    .sel_o      (sel_q),
    .mode_o     (mode_q),
    .stat_clr_o (stat_clr),
    .rdata_o    (reg_rdata_o)
  );

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    irq_trig_cell u_cell (
      .clk     (clk),
      .rst_n   (rst_n),
      .lvl_i   (src_now[g]),
      .lvl_q_i (src_prev[g]),
      .mode_i  (trig_mode_e'(mode_q[g*MODE_W +: MODE_W])),
      .en_i    (mask_q[g]),
      .clr_i   (stat_clr),
      .flag_o  (status_q[g])
    );
  end

  assign irq_n_o = ~(|status_q);

endmodule

// File: rtl/irq_combiner_chk.sv
module irq_combiner_chk #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              xfer_i,
  input logic              xfer_q,
  input logic [1:0]        status,
  input logic [1:0]        mask,
  input logic [3:0]        mode,
  input logic              re,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] rdata
);

  p_masked_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!mask[0] && !status[0]) |=> !status[0]);

  p_masked_quiet1_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!mask[1] && !status[1]) |=> !status[1]);

  p_reserved_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode[1:0] == 2'b11) |=> !status[0]);

  p_reserved_off1_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode[3:2] == 2'b11) |=> !status[1]);

  p_rise_sets_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode[1:0] == 2'b00 && mask[0] && xfer_i && !xfer_q) |=> status[0]);

  p_level_track_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode[1:0] == 2'b10) |=> (status[0] == $past(mask[0] & xfer_i)));

  p_status_upper_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (re && addr == '0) |-> (rdata[DATA_W-1:2] == '0));

endmodule

bind irq_combiner irq_combiner_chk #(
  .DATA_W (DATA_W),
  .ADDR_W (ADDR_W)
) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .xfer_i (xfer_done_i),
  .xfer_q (xfer_q),
  .status (status_q),
  .mask   (mask_q),
  .mode   (mode_q),
  .re     (reg_re_i),
  .addr   (reg_addr_i),
  .rdata  (reg_rdata_o)
);

// File: tb/test_irq_combiner.sv
`timescale 1ns/1ps
module test_irq_combiner;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       xfer = 1'b0, slip = 1'b0, blk = 1'b0;
  logic       we = 1'b0, re = 1'b0;
  logic [1:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       irq_n;
  int         checks = 0, failures = 0;
  bit         done = 1'b0;

  always #5 clk = ~clk;

  irq_combiner i_irq_combiner (
    .clk (clk), .rst_n (rst_n), .xfer_done_i (xfer), .slip_i (slip),
    .blk_start_i (blk), .reg_we_i (we), .reg_re_i (re), .reg_addr_i (addr),
    .reg_wdata_i (wdata), .reg_rdata_o (rdata), .irq_n_o (irq_n)
  );

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic wr(int a, int d);
    @(negedge clk); we = 1'b1; addr = 2'(a); wdata = 8'(d);
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(int a, output int d);
    @(negedge clk); re = 1'b1; addr = 2'(a);
    #1 d = int'(rdata);
    @(negedge clk); re = 1'b0;
  endtask

  task automatic drive(int src, int sel, bit other, bit v);
    if (src == 0) xfer = v;
    else if ((sel == 1) != other) blk = v;
    else slip = v;
  endtask

  function automatic string tag(int mode, int msk, int src);
    if (msk == 0) return "R7";
    if (mode == 0) return "R3";
    if (mode == 1) return "R4";
    if (mode == 2) return "R5";
    return "R6";
  endfunction

  task automatic run_pulse(int src, int sel, int mode, int msk, bit other);
    int d;
    bit eff, exp_hi, exp_lo;
    string t;
    t = other ? "R9" : tag(mode, msk, src);
    eff = (msk != 0) && !other;
    exp_hi = eff && (mode == 0 || mode == 2);
    exp_lo = eff && (mode == 0 || mode == 1);
    wr(1, (sel << 2) | (msk << src));
    wr(2, mode << (2 * src));
    rd(0, d);
    @(negedge clk); drive(src, sel, other, 1'b1);
    @(negedge clk); check(t, "irq after rise", int'(irq_n), int'(!exp_hi));
    @(negedge clk); check(t, "irq while high", int'(irq_n), int'(!exp_hi));
    drive(src, sel, other, 1'b0);
    @(negedge clk); check(t, "irq after fall", int'(irq_n), int'(!exp_lo));
    rd(0, d);
    check(t, "status bits", d, int'(exp_lo) << src);
    check("R8", "irq after status read", int'(irq_n), 1);
  endtask

  initial begin
    int d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset values
    check("R1", "irq_n", int'(irq_n), 1);
    rd(0, d); check("R1", "status", d, 0);
    rd(1, d); check("R1", "mask", d, 0);
    rd(2, d); check("R1", "mode", d, 0);
    // R2 / R12: register widths and status write ignored
    wr(1, 8'hFF); rd(1, d); check("R2", "mask readback", d, 8'h07);
    wr(2, 8'hFF); rd(2, d); check("R2", "mode readback", d, 8'h0F);
    wr(0, 8'hFF); rd(0, d); check("R12", "status write ignored", d, 0);
    check("R12", "irq after status write", int'(irq_n), 1);
    // Sweep: every mode x enable for each source / select
    for (int src = 0; src < 2; src++)
      for (int sel = 0; sel < 2; sel++)
        for (int mode = 0; mode < 4; mode++)
          for (int msk = 0; msk < 2; msk++)
            if (src == 1 || sel == 0) run_pulse(src, sel, mode, msk, 1'b0);
    // R9: unselected input ignored
    for (int sel = 0; sel < 2; sel++)
      for (int mode = 0; mode < 3; mode++) run_pulse(1, sel, mode, 1, 1'b1);
    // R8: read in same cycle as a new rising edge keeps the bit
    wr(1, 8'h01); wr(2, 8'h00); rd(0, d);
    @(negedge clk); xfer = 1'b1; re = 1'b1; addr = 2'd0;
    @(negedge clk); re = 1'b0;
    check("R8", "irq after read+edge", int'(irq_n), 0);
    rd(0, d); check("R8", "status after read+edge", d, 1);
    xfer = 1'b0;
    rd(0, d); check("R11", "irq released", int'(irq_n), 1);
    // R10: select switch onto a steady-high input makes no edge
    wr(2, 8'h00);
    wr(1, 8'h06); slip = 1'b1;
    repeat (3) @(negedge clk);
    wr(1, 8'h02);
    @(negedge clk);
    check("R10", "irq after select switch", int'(irq_n), 1);
    rd(0, d); check("R10", "status after select switch", d, 0);
    slip = 1'b0;
    // R11: both flags set, pin low until one read clears both
    wr(1, 8'h03); wr(2, 8'h00);
    @(negedge clk); xfer = 1'b1; slip = 1'b1;
    @(negedge clk); check("R11", "irq both set", int'(irq_n), 0);
    rd(0, d); check("R11", "status both", d, 3);
    check("R11", "irq cleared", int'(irq_n), 1);
    xfer = 1'b0; slip = 1'b0;
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule